// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

A bank of hardware lock tokens shared by two requesters, called the left side and the right side. Each side has a semaphore select, a memory select, a write strobe, a token address and a data bus. A side asks for a token by writing a 0 on data bit 0. It gives the token back, or withdraws a waiting request, by writing a 1. It learns whether it holds the token by reading that token's address: the read returns all zeros when the side owns the token and all ones when it does not.

Each token keeps a request flag for each side and an owner field. A request that arrives while the other side owns the token stays pending. It is granted in the same update in which the owner releases. When both sides ask for a free token in the same cycle, exactly one side becomes owner. A parameter sets which side that is, and the default is the left side. Software should read the token back after a write before it trusts the result. The read must be issued at least one cycle after the write.

Top module: `sema_token_bank`

## Requirements
- R1: After reset every token is free, and both read buses show all ones. A read of any free token returns all ones to both sides.
- R2: A side takes part in token traffic only when its semaphore select is 1 and its memory select is 0. A write or read made with both selects at 1, or with the semaphore select at 0, changes no token and does not update that side's read bus.
- R3: Only data bit 0 of a write is used. 0 requests the token and 1 releases it. The other data bits have no effect.
- R4: A read returns the requesting side's ownership replicated on every data bit: all zeros if that side owns the addressed token, all ones otherwise. The value appears on the read bus one clock after the read cycle.
- R5: A read issued in the same cycle as a write to the same token returns the state from before that write. A read issued one cycle later returns the updated state.
- R6: No token is ever owned by both sides at once.
- R7: A request for a token owned by the other side stays pending. It becomes ownership in the cycle the owner writes 1.
- R8: When both sides request the same free token in the same cycle, the left side (LEFT_WINS=1) becomes owner and the right side's request stays pending.
- R9: Writing 1 clears only the writer's own request and ownership. The other side's pending request is kept, and a withdrawn request is never granted.
- R10: Token address bits [2:0] select one of 8 independent tokens. Traffic on one token leaves every other token unchanged.
- R11: Between reads, a side's read bus holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_sel | input | 1 | Left memory select, active high (blocks token access) |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | 3 | Left token address |
| l_wdata | input | 16 | Left write data, bit 0 used |
| l_rdata | output | 16 | Left read data, registered |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_sel | input | 1 | Right memory select, active high (blocks token access) |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_addr | input | 3 | Right token address |
| r_wdata | input | 16 | Right write data, bit 0 used |
| r_rdata | output | 16 | Right read data, registered |

## Verification
The hardest states to reach are the ones where both sides act on one token in the same cycle: a simultaneous claim of a free token, a release by the owner while the other side's request waits, and a read in the very cycle of a write. The driver task sets both sides' inputs in one call, so these collisions are written as single stimulus steps. Expected read values go into per-side queues, and the monitor compares them one clock later. A withdrawal followed by the owner's release is also driven, to show that a cancelled request is never granted.

// File: rtl/sema_pkg.sv
package sema_pkg;

   typedef enum logic [1:0] {
      OWN_FREE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;

endpackage

// File: rtl/sema_side_decode.sv
module sema_side_decode #(
   parameter int N_TOKENS = 8,
   parameter int ADDR_W   = 3
) (
   input  logic                sem_sel,
   input  logic                mem_sel,
   input  logic                wr,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wbit,
   output logic [N_TOKENS-1:0] claim_vec,
   output logic [N_TOKENS-1:0] rel_vec,
   output logic                rd_stb
);

   localparam bit FULL_MAP = (N_TOKENS == (1 << ADDR_W));

   logic access;
   logic in_range;

   generate
      if (FULL_MAP) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = (int'(addr) < N_TOKENS);
      end
   endgenerate

   // semaphore space only when memory space is not selected
   assign access = sem_sel & ~mem_sel & in_range;
   assign rd_stb = access & ~wr;

   generate
      for (genvar i = 0; i < N_TOKENS; i++) begin : g_tok
         logic hit;
         assign hit          = access & wr & (addr == ADDR_W'(i));
         assign claim_vec[i] = hit & ~wbit;
         assign rel_vec[i]   = hit &  wbit;
      end
   endgenerate

endmodule

// File: rtl/sema_token.sv
module sema_token
   import sema_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic claim_l,
   input  logic rel_l,
   input  logic claim_r,
   input  logic rel_r,
   output logic own_l,
   output logic own_r
);

   owner_t owner_q, owner_d, tie_side;
   logic   req_l_q, req_l_d;
   logic   req_r_q, req_r_d;

   generate
      if (LEFT_WINS) begin : g_tie_left
         assign tie_side = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_side = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      req_l_d = req_l_q;
      if (claim_l)    req_l_d = 1'b1;
      else if (rel_l) req_l_d = 1'b0;

      req_r_d = req_r_q;
      if (claim_r)    req_r_d = 1'b1;
      else if (rel_r) req_r_d = 1'b0;

      // holder keeps the token while its request stands
      if (owner_q == OWN_LEFT && req_l_d)
         owner_d = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && req_r_d)
         owner_d = OWN_RIGHT;
      else if (req_l_d && req_r_d)
         owner_d = tie_side;
      else if (req_l_d)
         owner_d = OWN_LEFT;
      else if (req_r_d)
         owner_d = OWN_RIGHT;
      else
         owner_d = OWN_FREE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= OWN_FREE;
         req_l_q <= 1'b0;
         req_r_q <= 1'b0;
      end else begin
         owner_q <= owner_d;
         req_l_q <= req_l_d;
         req_r_q <= req_r_d;
      end
   end

   assign own_l = (owner_q == OWN_LEFT);
   assign own_r = (owner_q == OWN_RIGHT);

endmodule

// File: rtl/sema_readback.sv
module sema_readback #(
   parameter int N_TOKENS = 8,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_stb,
   input  logic [ADDR_W-1:0]   rd_idx,
   input  logic [N_TOKENS-1:0] own_vec,
   output logic [DATA_W-1:0]   rdata
);

   logic held;

   assign held = own_vec[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '1;
      else if (rd_stb)
         rdata <= {DATA_W{~held}};
   end

endmodule

// File: rtl/sema_token_bank.sv
module sema_token_bank #(
   parameter int N_TOKENS  = 8,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1,
   parameter int ADDR_W    = (N_TOKENS > 1) ? $clog2(N_TOKENS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_mem_sel,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_sel,
   input  logic              r_mem_sel,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   initial begin : p_param_chk
      assert (N_TOKENS >= 2)
         else $fatal(1, "sema_token_bank: N_TOKENS must be at least 2");
      assert (DATA_W >= 1)
         else $fatal(1, "sema_token_bank: DATA_W must be at least 1");
      assert ((1 << ADDR_W) >= N_TOKENS)
         else $fatal(1, "sema_token_bank: ADDR_W too small for N_TOKENS");
   end

   logic [N_TOKENS-1:0] l_claim, l_rel, r_claim, r_rel;
   logic [N_TOKENS-1:0] own_l_vec, own_r_vec;
   logic                l_rd_stb, r_rd_stb;

   generate
      if (DATA_W > 1) begin : g_unused_hi
         logic unused_hi;
         assign unused_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};
      end
   endgenerate

   sema_side_decode #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W)) u_dec_l (
      .sem_sel   (l_sem_sel),
      .mem_sel   (l_mem_sel),
      .wr        (l_wr),
      .addr      (l_addr),
      .wbit      (l_wdata[0]),
      .claim_vec (l_claim),
      .rel_vec   (l_rel),
      .rd_stb    (l_rd_stb)
   );

   sema_side_decode #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W)) u_dec_r (
      .sem_sel   (r_sem_sel),
      .mem_sel   (r_mem_sel),
      .wr        (r_wr),
      .addr      (r_addr),
      .wbit      (r_wdata[0]),
      .claim_vec (r_claim),
      .rel_vec   (r_rel),
      .rd_stb    (r_rd_stb)
   );

   generate
      for (genvar i = 0; i < N_TOKENS; i++) begin : g_bank
         sema_token #(.LEFT_WINS(LEFT_WINS)) u_tok (
            .clk     (clk),
            .rst_n   (rst_n),
            .claim_l (l_claim[i]),
            .rel_l   (l_rel[i]),
            .claim_r (r_claim[i]),
            .rel_r   (r_rel[i]),
            .own_l   (own_l_vec[i]),
            .own_r   (own_r_vec[i])
         );
      end
   endgenerate

   sema_readback #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rb_l (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (l_rd_stb),
      .rd_idx  (l_addr),
      .own_vec (own_l_vec),
      .rdata   (l_rdata)
   );

   sema_readback #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rb_r (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (r_rd_stb),
      .rd_idx  (r_addr),
      .own_vec (own_r_vec),
      .rdata   (r_rdata)
   );

endmodule

// File: rtl/sema_token_bank_chk.sv
module sema_token_bank_chk #(
   parameter int N_TOKENS  = 8,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1,
   parameter int ADDR_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                l_sem_sel,
   input logic                l_mem_sel,
   input logic                l_wr,
   input logic [ADDR_W-1:0]   l_addr,
   input logic [DATA_W-1:0]   l_wdata,
   input logic [DATA_W-1:0]   l_rdata,
   input logic                r_sem_sel,
   input logic                r_mem_sel,
   input logic                r_wr,
   input logic [ADDR_W-1:0]   r_addr,
   input logic [DATA_W-1:0]   r_wdata,
   input logic [DATA_W-1:0]   r_rdata,
   input logic [N_TOKENS-1:0] own_l_vec,
   input logic [N_TOKENS-1:0] own_r_vec
);

   logic l_ok, r_ok, l_read, r_read, l_blocked, r_write;
   logic both_claim_free;

   assign l_ok      = l_sem_sel & ~l_mem_sel;
   assign r_ok      = r_sem_sel & ~r_mem_sel;
   assign l_read    = l_ok & ~l_wr;
   assign r_read    = r_ok & ~r_wr;
   assign l_blocked = l_sem_sel & l_mem_sel;
   assign r_write   = r_ok & r_wr;
   assign both_claim_free = l_ok & l_wr & ~l_wdata[0] & r_ok & r_wr & ~r_wdata[0]
                          & (l_addr == r_addr) & (int'(l_addr) < N_TOKENS)
                          & ~own_l_vec[l_addr] & ~own_r_vec[l_addr];

   // R6
   excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l_vec & own_r_vec) == '0);

   // R2
   blocked_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_blocked && !r_write) |=> ($stable(own_l_vec) && $stable(own_r_vec)));

   // R4
   rd_replicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_read || r_read) |=> ((l_rdata == '0 || l_rdata == '1) &&
                              (r_rdata == '0 || r_rdata == '1)));

   // R11
   l_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l_read |=> $stable(l_rdata));

   // R11
   r_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !r_read |=> $stable(r_rdata));

   generate
      if (LEFT_WINS) begin : g_tie_l
         // R8
         tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
            both_claim_free |=> own_l_vec[$past(l_addr)]);
      end else begin : g_tie_r
         // R8
         tie_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
            both_claim_free |=> own_r_vec[$past(r_addr)]);
      end
   endgenerate

endmodule

bind sema_token_bank sema_token_bank_chk #(
   .N_TOKENS  (N_TOKENS),
   .DATA_W    (DATA_W),
   .LEFT_WINS (LEFT_WINS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .l_sem_sel (l_sem_sel),
   .l_mem_sel (l_mem_sel),
   .l_wr      (l_wr),
   .l_addr    (l_addr),
   .l_wdata   (l_wdata),
   .l_rdata   (l_rdata),
   .r_sem_sel (r_sem_sel),
   .r_mem_sel (r_mem_sel),
   .r_wr      (r_wr),
   .r_addr    (r_addr),
   .r_wdata   (r_wdata),
   .r_rdata   (r_rdata),
   .own_l_vec (own_l_vec),
   .own_r_vec (own_r_vec)
);

// File: tb/sema_token_bank_tb.sv
`timescale 1ns/1ps
module sema_token_bank_tb;

   localparam int AW = 3;
   localparam int DW = 16;
   localparam logic [DW-1:0] ONES  = '1;
   localparam logic [DW-1:0] ZEROS = '0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l_sel = 1'b0, l_mem = 1'b0, l_wr = 1'b0;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wd = '0;
   logic [DW-1:0] l_rd;
   logic          r_sel = 1'b0, r_mem = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wd = '0;
   logic [DW-1:0] r_rd;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   logic [DW-1:0] ql[$];
   logic [DW-1:0] qr[$];
   string         tql[$];
   string         tqr[$];
   logic          mon_l = 1'b0, mon_r = 1'b0;

   always #4 clk = ~clk;

   sema_token_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .l_sem_sel (l_sel),
      .l_mem_sel (l_mem),
      .l_wr      (l_wr),
      .l_addr    (l_addr),
      .l_wdata   (l_wd),
      .l_rdata   (l_rd),
      .r_sem_sel (r_sel),
      .r_mem_sel (r_mem),
      .r_wr      (r_wr),
      .r_addr    (r_addr),
      .r_wdata   (r_wd),
      .r_rdata   (r_rd)
   );

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: a read issued in one cycle shows up after the next edge
   always @(posedge clk) begin
      mon_l <= rst_n & l_sel & ~l_mem & ~l_wr;
      mon_r <= rst_n & r_sel & ~r_mem & ~r_wr;
   end

   always @(negedge clk) begin
      if (mon_l && ql.size() > 0) check(l_rd, ql.pop_front(), tql.pop_front());
      if (mon_r && qr.size() > 0) check(r_rd, qr.pop_front(), tqr.pop_front());
   end

   // driver: one cycle of both sides; read expectations go to the scoreboard
   task automatic step(
      input logic ls, input logic lm, input logic lw, input logic [AW-1:0] la,
      input logic [DW-1:0] ld, input logic lown, input string ltag,
      input logic rs, input logic rm, input logic rw, input logic [AW-1:0] ra,
      input logic [DW-1:0] rdv, input logic rown, input string rtag);
      @(negedge clk);
      l_sel = ls; l_mem = lm; l_wr = lw; l_addr = la; l_wd = ld;
      r_sel = rs; r_mem = rm; r_wr = rw; r_addr = ra; r_wd = rdv;
      if (ls && !lm && !lw) begin ql.push_back(lown ? ZEROS : ONES); tql.push_back(ltag); end
      if (rs && !rm && !rw) begin qr.push_back(rown ? ZEROS : ONES); tqr.push_back(rtag); end
      @(posedge clk);
   endtask

   task automatic idle();
      step(0,0,0,0,0,0,"", 0,0,0,0,0,0,"");
   endtask
   task automatic wl(input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(1,0,1,a,d,0,"", 0,0,0,0,0,0,"");
   endtask
   task automatic wrr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(0,0,0,0,0,0,"", 1,0,1,a,d,0,"");
   endtask
   task automatic rl(input logic [AW-1:0] a, input logic own, input string tag);
      step(1,0,0,a,0,own,tag, 0,0,0,0,0,0,"");
   endtask
   task automatic rr(input logic [AW-1:0] a, input logic own, input string tag);
      step(0,0,0,0,0,0,"", 1,0,0,a,0,own,tag);
   endtask

   initial begin : watchdog
      #(8 * 100000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(l_rd, ONES, "R1 reset left");
      check(r_rd, ONES, "R1 reset right");
      rst_n = 1'b1;

      // R1: all tokens free, both sides read ones
      for (int i = 0; i < 8; i++) step(1,0,0,AW'(i),0,0,"R1", 1,0,0,AW'(i),0,0,"R1");

      // R3: claim with upper bits set, bit 0 clear
      wl(3, 16'hFFFE);
      rl(3, 1, "R3 claim via bit0");
      rr(3, 0, "R4 non-owner reads ones");

      // R7: right waits on token 3
      wrr(3, 16'h0000);
      rr(3, 0, "R7 still pending");
      rl(3, 1, "R6 left keeps token");

      // R5: left releases (bit0=1, upper clear) while right reads same cycle
      step(1,0,1,3,16'h0001,0,"", 1,0,0,3,0,0,"R5 same-cycle read sees old state");
      rr(3, 1, "R7 pending granted on release");
      rl(3, 0, "R9 releaser lost ownership");

      // R10: tokens are independent
      rl(2, 0, "R10 token 2 free");
      wrr(2, 16'hFFFE);
      rr(2, 1, "R10 right owns 2");
      rr(3, 1, "R10 token 3 untouched");
      rl(2, 0, "R10 left not owner of 2");

      // R2: both selects high -> ignored
      step(1,1,1,6,16'h0000,0,"", 0,0,0,0,0,0,"");
      rl(6, 0, "R2 blocked write ignored");
      wrr(6, 16'h0000);
      rr(6, 1, "R2 right granted, no hidden left request");
      // blocked read must not touch the read bus (was ones)
      step(1,1,0,2,0,0,"", 0,0,0,0,0,0,"");
      @(negedge clk);
      check(l_rd, ONES, "R2 blocked read leaves bus");
      // semaphore select low -> ignored
      step(1'b0,0,1,7,16'h0000,0,"", 0,0,0,0,0,0,"");
      wrr(7, 16'h0000);
      rr(7, 1, "R2 unselected write ignored");

      // R8: simultaneous claim of free token 1
      step(1,0,1,1,16'h0000,0,"", 1,0,1,1,16'h0000,0,"");
      step(1,0,0,1,0,1,"R8 left wins tie", 1,0,0,1,0,0,"R8 right loses tie");
      wl(1, 16'h0001);
      rr(1, 1, "R8 loser granted after release");
      rl(1, 0, "R6 left no longer owner");

      // R9: withdrawn request is never granted
      wl(4, 16'h0000);
      wrr(4, 16'h0000);
      wrr(4, 16'hFFFF);
      wl(4, 16'h0001);
      step(1,0,0,4,0,0,"R9 token free after withdraw", 1,0,0,4,0,0,"R9 withdrawn not granted");

      // R6: right holds 0, left request does not take it
      wrr(0, 16'h0000);
      wl(0, 16'h0000);
      step(1,0,0,0,0,0,"R6 left excluded", 1,0,0,0,0,1,"R6 right holds");

      // R11: read bus holds between reads
      wl(5, 16'h0000);
      rl(5, 1, "R11 owner read");
      wrr(5, 16'h0000);
      step(1,1,0,5,0,0,"", 0,0,0,0,0,0,"");
      idle();
      @(negedge clk);
      check(l_rd, ZEROS, "R11 left bus held");

      idle();
      idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule